// File: doc/BRIEF.md
# Snooping Write-Through Data Cache

This block is a small data cache placed between one processor and a shared system bus that reaches a single memory. Several copies of it can share one bus and still present a coherent view of memory. When a read finds its word in the cache, the cache answers it directly. A read that misses fetches the word from memory and keeps a copy. Every write goes out to memory, so memory always holds the newest value.

Each cache also watches the writes that other bus masters make. If another master writes an address that this cache holds, the local copy is dropped. The next local read of that address then misses and fetches the new value. The cache is direct-mapped with one word per line. The line index comes from the low word-address bits and the tag from the remaining upper bits.

On the processor side, a request is taken in any cycle where `cpu_req` and `cpu_ready` are both high. A read answers with a one-cycle `cpu_rvalid` pulse. On the bus side, the cache raises `bus_req` and waits for `bus_gnt`. Memory then returns read data with a `bus_rvalid` strobe.

Top module: `swt_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address misses. In the reset state `cpu_ready` is 1, `bus_req` is 0 and `cpu_rvalid` is 0.
- R2: An accepted read that hits raises `cpu_rvalid` in the next cycle with the cached word, and `bus_req` stays 0.
- R3: An accepted read that misses raises `bus_req` with `bus_we`=0 and `bus_addr` equal to the request address. In the cycle after `bus_rvalid`, the cache gives `cpu_rvalid` with that data and stores the word, so the next read of the address hits.
- R4: Every accepted write raises `bus_req` in the next cycle, with `bus_we`=1, the request address and data, and `bus_id` equal to the `MY_ID` parameter. The write completes at the grant, and `cpu_ready` is 1 in the following cycle. A write that hits also updates the cached word.
- R5: A write that misses does not allocate a line, so a later read of that address misses.
- R6: While `bus_req` is 1 and `bus_gnt` is 0, `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` hold their values into the next cycle.
- R7: `cpu_ready` is 0 from the acceptance of a miss or a write until that transfer completes.
- R8: When `snp_wr` is 1, `snp_id` differs from `MY_ID`, and the line at the snooped index is valid with a matching tag, that line becomes invalid. A snoop whose tag differs from the stored tag leaves the line valid.
- R9: A snooped write whose `snp_id` equals `MY_ID` changes no line.
- R10: When a snoop and a fill reach the same index in the same cycle, the snoop is applied after the fill. A snoop of the address being filled leaves the line invalid. A snoop of another tag at that index leaves the filled line valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Cache can accept a request |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | DATA_W | Read data |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_we | output | 1 | Bus transfer is a write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_id | output | ID_W | Master identifier of this cache |
| bus_rvalid | input | 1 | Memory read data strobe |
| bus_rdata | input | DATA_W | Memory read data |
| snp_wr | input | 1 | A bus write is being observed |
| snp_addr | input | ADDR_W | Address of the observed write |
| snp_id | input | ID_W | Master that issued the observed write |

## Verification
The assertions check these rules on every cycle:
- the bus request stays stable until it is granted;
- a hit is answered locally within one cycle;
- a fill returns the bus data to the processor;
- every write goes out on the bus;
- snoops kill matching lines, ignore this cache's own writes, and win against a fill to the same address.

Some behaviour only the bench scenarios can show, because it spans several transactions. The bench sweeps every line index through a miss and then a hit. It also shows:
- that a write miss leaves nothing behind;
- that an invalidated address brings the other master's new value on the next read;
- that a snoop of a different tag leaves a line usable;
- that the line is left in the right state after each of the two fill-race cases.

// File: rtl/swt_pkg.sv
package swt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } swt_state_e;
endpackage

// File: rtl/swt_rst_sync.sv
module swt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/swt_line_store.sv
module swt_line_store #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  parameter int ID_W   = 2,
  parameter logic [ID_W-1:0] MY_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snp_wr,
  input  logic [IDX_W-1:0]  snp_idx,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic [ID_W-1:0]   snp_id
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q, valid_nxt;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];
  logic [TAG_W-1:0]  snp_cmp_tag;
  logic              snp_kill;

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];

  // Fill first, then snoop: compare against the tag the line will hold.
  always_comb begin
    valid_nxt = valid_q;
    if (fill_en) valid_nxt[fill_idx] = 1'b1;
    snp_cmp_tag = (fill_en && (fill_idx == snp_idx)) ? fill_tag : tag_mem[snp_idx];
    snp_kill = snp_wr && (snp_id != MY_ID) && valid_nxt[snp_idx] &&
               (snp_cmp_tag == snp_tag);
    if (snp_kill) valid_nxt[snp_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_nxt;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_mem[fill_idx]  <= fill_tag;
      data_mem[fill_idx] <= fill_data;
    end
    if (wr_en) data_mem[wr_idx] <= wr_data;
  end

  // R8
  snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_wr && (snp_id != MY_ID) && !fill_en && valid_q[snp_idx] &&
     (tag_mem[snp_idx] == snp_tag)) |=> !valid_q[$past(snp_idx)]);

  // R9
  own_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_wr && (snp_id == MY_ID) && !fill_en) |=> $stable(valid_q));

  // R10
  fill_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && snp_wr && (snp_id != MY_ID) && (snp_idx == fill_idx) &&
     (snp_tag == fill_tag)) |=> !valid_q[$past(fill_idx)]);
endmodule

// File: rtl/swt_ctrl.sv
module swt_ctrl
  import swt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic                    rd_valid,
  input  logic [ADDR_W-IDX_W-1:0] rd_tag,
  input  logic [DATA_W-1:0]       rd_data,
  output logic              wr_en,
  output logic              fill_en
);
  swt_state_e        st_q, st_nxt;
  logic              rv_q, rv_nxt;
  logic [DATA_W-1:0] rd_q, rd_nxt;
  logic              lat_we_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_wdata_q;
  logic              accept, hit, lat_en;

  assign accept = cpu_req && (st_q == ST_IDLE);
  assign hit    = rd_valid && (rd_tag == cpu_addr[ADDR_W-1:IDX_W]);
  assign lat_en = accept && (cpu_we || !hit);

  always_comb begin
    st_nxt  = st_q;
    rv_nxt  = 1'b0;
    rd_nxt  = rd_q;
    wr_en   = 1'b0;
    fill_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        if (!cpu_we && hit) begin
          rv_nxt = 1'b1;
          rd_nxt = rd_data;
        end else begin
          st_nxt = ST_REQ;
        end
        wr_en = cpu_we && hit;
      end
      ST_REQ:  if (bus_gnt) st_nxt = lat_we_q ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (bus_rvalid) begin
        fill_en = 1'b1;
        rv_nxt  = 1'b1;
        rd_nxt  = bus_rdata;
        st_nxt  = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rv_q        <= 1'b0;
      rd_q        <= '0;
      lat_we_q    <= 1'b0;
      lat_addr_q  <= '0;
      lat_wdata_q <= '0;
    end else begin
      st_q <= st_nxt;
      rv_q <= rv_nxt;
      rd_q <= rd_nxt;
      if (lat_en) begin
        lat_we_q    <= cpu_we;
        lat_addr_q  <= cpu_addr;
        lat_wdata_q <= cpu_wdata;
      end
    end
  end

  assign cpu_ready  = (st_q == ST_IDLE);
  assign cpu_rvalid = rv_q;
  assign cpu_rdata  = rd_q;
  assign bus_req    = (st_q == ST_REQ);
  assign bus_we     = lat_we_q;
  assign bus_addr   = lat_addr_q;
  assign bus_wdata  = lat_wdata_q;

  // R6
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) &&
                               $stable(bus_we) && $stable(bus_wdata)));

  // R2
  hit_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready && !cpu_we && hit) |=>
      (cpu_rvalid && !bus_req && (cpu_rdata == $past(rd_data))));

  // R3
  fill_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ready && !bus_req && bus_rvalid) |=>
      (cpu_rvalid && cpu_ready && (cpu_rdata == $past(bus_rdata))));

  // R4
  write_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready && cpu_we) |=>
      (bus_req && bus_we && !cpu_ready && (bus_addr == $past(cpu_addr)) &&
       (bus_wdata == $past(cpu_wdata))));
endmodule

// File: rtl/swt_cache.sv
module swt_cache #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  parameter int ID_W   = 2,
  parameter logic [ID_W-1:0] MY_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [ID_W-1:0]   bus_id,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_wr,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              rst_i_n;
  logic              rd_valid, wr_en, fill_en;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;

  assign bus_id = MY_ID;

  swt_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  swt_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(wr_en), .fill_en(fill_en)
  );

  swt_line_store #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)
  ) u_store (
    .clk(clk), .rst_n(rst_i_n),
    .rd_idx(cpu_addr[IDX_W-1:0]), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(cpu_addr[IDX_W-1:0]), .wr_data(cpu_wdata),
    .fill_en(fill_en), .fill_idx(bus_addr[IDX_W-1:0]),
    .fill_tag(bus_addr[ADDR_W-1:IDX_W]), .fill_data(bus_rdata),
    .snp_wr(snp_wr), .snp_idx(snp_addr[IDX_W-1:0]),
    .snp_tag(snp_addr[ADDR_W-1:IDX_W]), .snp_id(snp_id)
  );
endmodule

// File: tb/tb_swt_cache.sv
module tb_swt_cache;
  localparam int ADDR_W = 10;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 32;
  localparam int ID_W   = 2;
  localparam logic [ID_W-1:0] MY = 2'd1;
  localparam int LINES  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ready, cpu_rvalid;
  logic [DATA_W-1:0] cpu_rdata;
  logic bus_req, bus_we;
  logic bus_gnt = 1'b0, bus_rvalid = 1'b0;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic [ID_W-1:0] bus_id;
  logic snp_wr = 1'b0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [ID_W-1:0] snp_id = '0;

  int n_chk = 0, n_bad = 0;
  logic [DATA_W-1:0] mem [1 << ADDR_W];

  always #4 clk = ~clk;

  swt_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .ID_W(ID_W),
              .MY_ID(MY)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_id(bus_id), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .snp_wr(snp_wr), .snp_addr(snp_addr),
    .snp_id(snp_id)
  );

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
    return ADDR_W'((tag << IDX_W) | idx);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // One processor transfer with the bus serviced in the bench.
  task automatic op(input logic we, input logic [ADDR_W-1:0] a,
                    input logic [DATA_W-1:0] wd, input int dly,
                    input logic race, input logic [ADDR_W-1:0] sa,
                    input logic [ID_W-1:0] sid,
                    output logic [DATA_W-1:0] rd, output logic used);
    int waited = 0, guard = 0;
    logic gdone = 1'b0, done = 1'b0;
    logic [ADDR_W-1:0] a0 = '0;
    logic we0 = 1'b0;
    logic [DATA_W-1:0] d0 = '0;
    used = 1'b0; rd = '0;
    @(negedge clk);
    chk(cpu_ready, "R7 ready before request", 64'(cpu_ready), 1);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    while (!done && guard < 100) begin
      guard++;
      if (cpu_rvalid) begin
        rd = cpu_rdata; done = 1'b1;
      end else if (we && gdone) begin
        chk(cpu_ready, "R4 ready after write grant", 64'(cpu_ready), 1);
        done = 1'b1;
      end else if (bus_req) begin
        chk(!cpu_ready, "R7 ready low during transfer", 64'(cpu_ready), 0);
        if (!used) begin
          used = 1'b1; a0 = bus_addr; we0 = bus_we; d0 = bus_wdata;
          chk(bus_addr == a, "R3 R4 bus address", 64'(bus_addr), 64'(a));
          chk(bus_we == we, "R3 R4 bus direction", 64'(bus_we), 64'(we));
          chk(bus_id == MY, "R4 bus id", 64'(bus_id), 64'(MY));
          if (we) chk(bus_wdata == wd, "R4 bus data", 64'(bus_wdata), 64'(wd));
        end else begin
          chk(bus_addr == a0 && bus_we == we0 && bus_wdata == d0,
              "R6 held request", 64'(bus_addr), 64'(a0));
        end
        if (waited == dly) begin
          bus_gnt = 1'b1;
          @(negedge clk);
          bus_gnt = 1'b0; gdone = 1'b1;
          if (we) mem[a] = wd;
          else begin
            chk(!cpu_ready && !bus_req, "R7 waiting for data", 64'(cpu_ready), 0);
            bus_rvalid = 1'b1; bus_rdata = mem[a];
            if (race) begin snp_wr = 1'b1; snp_addr = sa; snp_id = sid; end
            @(negedge clk);
            bus_rvalid = 1'b0; snp_wr = 1'b0;
          end
        end else begin
          waited++;
          @(negedge clk);
        end
      end else begin
        @(negedge clk);
      end
    end
    chk(done, "R3 transfer completes", 64'(done), 1);
  endtask

  task automatic rd_expect(input logic [ADDR_W-1:0] a, input logic exp_miss,
                           input int dly, input string req);
    logic [DATA_W-1:0] d;
    logic u;
    op(1'b0, a, '0, dly, 1'b0, '0, '0, d, u);
    chk(d == mem[a], req, 64'(d), 64'(mem[a]));
    chk(u == exp_miss, req, 64'(u), 64'(exp_miss));
  endtask

  task automatic snoop(input logic [ADDR_W-1:0] a, input logic [ID_W-1:0] id,
                       input logic [DATA_W-1:0] nv);
    @(negedge clk);
    snp_wr = 1'b1; snp_addr = a; snp_id = id;
    @(negedge clk);
    snp_wr = 1'b0;
    mem[a] = nv;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] d;
    logic u;
    for (int a = 0; a < (1 << ADDR_W); a++)
      mem[a] = DATA_W'(a) * 32'h9E37_79B1 ^ 32'h5A5A_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cpu_ready && !bus_req && !cpu_rvalid, "R1 reset outputs",
        {61'd0, cpu_ready, bus_req, cpu_rvalid}, 64'h4);

    // R1 R3: every index misses first time
    for (int i = 0; i < LINES; i++) rd_expect(mk(0, i), 1'b1, i % 3, "R1 R3 first read");
    // R2: every index now hits
    for (int i = 0; i < LINES; i++) rd_expect(mk(0, i), 1'b0, 0, "R2 read hit");

    // conflict at one index replaces the line
    rd_expect(mk(1, 5), 1'b1, 1, "R3 conflict miss");
    rd_expect(mk(1, 5), 1'b0, 0, "R2 hit after refill");
    rd_expect(mk(0, 5), 1'b1, 0, "R3 evicted line misses");

    // R4: write hit updates cache and memory
    op(1'b1, mk(0, 7), 32'hCAFE_0007, 2, 1'b0, '0, '0, d, u);
    chk(u, "R4 write hit goes to bus", 64'(u), 1);
    rd_expect(mk(0, 7), 1'b0, 0, "R4 write hit updates line");

    // R5: write miss does not allocate
    op(1'b1, mk(3, 9), 32'hBEEF_0009, 0, 1'b0, '0, '0, d, u);
    chk(u, "R4 write miss goes to bus", 64'(u), 1);
    rd_expect(mk(3, 9), 1'b1, 0, "R5 no allocate on write miss");

    // R8: snoop from another master
    snoop(mk(0, 10), 2'd2, 32'h1111_000A);
    rd_expect(mk(0, 10), 1'b1, 0, "R8 snoop invalidates");
    snoop(mk(2, 11), 2'd3, mem[mk(2, 11)] ^ 32'h1);
    rd_expect(mk(0, 11), 1'b0, 0, "R8 other tag keeps line");

    // R9: own writes are ignored
    snoop(mk(0, 12), MY, mem[mk(0, 12)]);
    rd_expect(mk(0, 12), 1'b0, 0, "R9 own id ignored");

    // R10: snoop racing a fill
    op(1'b0, mk(1, 20), '0, 1, 1'b1, mk(1, 20), 2'd2, d, u);
    chk(u && d == mem[mk(1, 20)], "R10 race fill data", 64'(d), 64'(mem[mk(1, 20)]));
    rd_expect(mk(1, 20), 1'b1, 0, "R10 same address left invalid");
    op(1'b0, mk(1, 21), '0, 0, 1'b1, mk(0, 21), 2'd3, d, u);
    rd_expect(mk(1, 21), 1'b0, 0, "R10 other tag keeps fill");

    // R8 sweep: invalidate every line by other masters, then all miss
    for (int i = 0; i < LINES; i++) rd_expect(mk(2, i), i != 21 || 1'b1, 0, "R3 sweep fill");
    for (int i = 0; i < LINES; i++) snoop(mk(2, i), 2'd0, mem[mk(2, i)] + 32'd1);
    for (int i = 0; i < LINES; i++) rd_expect(mk(2, i), 1'b1, i % 2, "R8 sweep invalidate");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule